// File: doc/BRIEF.md
# PAM4 Transmit De-emphasis Filter

This block sits in a serial transmit path just ahead of the digital-to-analog converter. Each clock it may accept one 2-bit symbol. The symbol is turned into one of four signed amplitude levels. The level stream then passes through a three-tap FIR whose taps act on the following symbol, the current symbol and the preceding symbol. The filter pre-distorts the waveform so that the channel's smearing is partly cancelled at the receiver, which mainly reduces inter-symbol interference.

The tap that acts on the following symbol must see that symbol before the current one can be output, so the output lags by one symbol. The result is clamped to a signed DAC code. The three signed tap weights are presented on input ports and copied into the active set only when a load strobe is high. A weight change therefore always takes effect between two output samples and never part way through one. Cycles with no valid symbol freeze the filter history and leave the output value unchanged.

Top module: `pam4_deemph_fir`

## Requirements
- R1: A symbol code maps to a signed amplitude as follows: 2'b00 to -3, 2'b01 to -1, 2'b11 to +1 and 2'b10 to +3.
- R2: A symbol x accepted at clock edge k is the following symbol of the sample produced at that edge. Let c and p be the two symbols accepted before x, with c the more recent. From edge k, dac_o equals clamp(w_pre*amp(x) + w_main*amp(c) + w_post*amp(p)), where the w values are the active tap weights.
- R3: dac_vld_o is high in exactly the clock after each edge where sym_vld_i was high, and low after each edge where it was low.
- R4: An edge with sym_vld_i low changes neither the symbol history nor dac_o, whatever sym_i carries.
- R5: The sum is clamped to the signed OUT_W range. With the defaults, sums above 127 give 127 and sums below -128 give -128.
- R6: Tap weights are 6-bit two's complement values. They are copied from coef_pre_i, coef_main_i and coef_post_i only at an edge where coef_load_i is high. A sample produced at that same edge still uses the previous weights. At all other edges the weight inputs are ignored.
- R7: While rst_n is low, dac_o is 0 and dac_vld_o is 0. Reset also sets all tap weights to 0 and fills the history with amplitude-0 entries. The internal reset ends two clock edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sym_i | input | 2 | Symbol code |
| sym_vld_i | input | 1 | Symbol strobe |
| coef_pre_i | input | COEF_W | Weight for the following-symbol tap |
| coef_main_i | input | COEF_W | Weight for the current-symbol tap |
| coef_post_i | input | COEF_W | Weight for the preceding-symbol tap |
| coef_load_i | input | 1 | Copies the three weight inputs into the active set |
| dac_o | output | OUT_W | Clamped signed DAC code |
| dac_vld_o | output | 1 | dac_o holds a new sample |

## Verification
The checker keeps its own model of the symbol history and the active weights, and it recomputes the clamped sum. On every cycle it compares that sum with dac_o. On every cycle it also checks the one-clock valid timing, checks that dac_o holds across idle cycles, checks that clamping takes place at both range limits, and checks that the outputs are cleared during reset. Some behaviours show only in the bench's scenarios: the literal mapping of each code, the exact edge at which a weight load takes effect, and the fact that idle symbols leave no trace in later samples. The bench covers these with exhaustive sweeps of all symbol triples over several weight sets, including the extreme values.

// File: rtl/pam4_fir_pkg.sv
package pam4_fir_pkg;
  localparam int SYM_W = 2;
  localparam int AMP_W = 3;
  localparam int NTAPS = 3;

  // Gray-ordered level mapping
  function automatic logic signed [AMP_W-1:0] code_to_amp(input logic [SYM_W-1:0] code);
    case (code)
      2'b00:   code_to_amp = -3'sd3;
      2'b01:   code_to_amp = -3'sd1;
      2'b11:   code_to_amp = 3'sd1;
      default: code_to_amp = 3'sd3;
    endcase
  endfunction
endpackage

// File: rtl/pam4_rst_sync.sv
module pam4_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pam4_sym_map.sv
module pam4_sym_map
  import pam4_fir_pkg::*;
(
  input  logic [SYM_W-1:0]        code_i,
  output logic signed [AMP_W-1:0] amp_o
);
  always_comb begin
    amp_o = code_to_amp(code_i);
  end
endmodule

// File: rtl/pam4_coef_bank.sv
module pam4_coef_bank #(
  parameter int COEF_W = 6,
  parameter int NTAPS  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [NTAPS*COEF_W-1:0] coef_in_i,
  output logic [NTAPS*COEF_W-1:0] coef_o
);
  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    logic [COEF_W-1:0] w_q;
    logic [COEF_W-1:0] w_d;

    always_comb begin
      w_d = w_q;
      if (load_i) w_d = coef_in_i[t*COEF_W +: COEF_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) w_q <= '0;
      else        w_q <= w_d;
    end

    assign coef_o[t*COEF_W +: COEF_W] = w_q;
  end
endmodule

// File: rtl/pam4_tap_line.sv
module pam4_tap_line #(
  parameter int AMP_W = 3,
  parameter int NTAPS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_i,
  input  logic [AMP_W-1:0]       amp_i,
  output logic [NTAPS*AMP_W-1:0] taps_o
);
  localparam int DEPTH = NTAPS - 1;

  logic [AMP_W-1:0] stage_q [DEPTH];
  logic [AMP_W-1:0] stage_d [DEPTH];

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      stage_d[k] = stage_q[k];
      if (shift_i) stage_d[k] = (k == 0) ? amp_i : stage_q[(k == 0) ? 0 : k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) stage_q[k] <= stage_d[k];
    end
  end

  // slot 0 = incoming (following) symbol, higher slots = older symbols
  assign taps_o[AMP_W-1:0] = amp_i;
  for (genvar k = 0; k < DEPTH; k++) begin : g_out
    assign taps_o[(k+1)*AMP_W +: AMP_W] = stage_q[k];
  end
endmodule

// File: rtl/pam4_fir_core.sv
module pam4_fir_core #(
  parameter int COEF_W = 6,
  parameter int AMP_W  = 3,
  parameter int OUT_W  = 8,
  parameter int NTAPS  = 3
) (
  input  logic [NTAPS*COEF_W-1:0] coef_i,
  input  logic [NTAPS*AMP_W-1:0]  taps_i,
  output logic [OUT_W-1:0]        sat_o
);
  localparam int PROD_W = COEF_W + AMP_W;
  localparam int ACC_W  = PROD_W + $clog2(NTAPS);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

  logic signed [PROD_W-1:0] prod [NTAPS];
  logic signed [ACC_W-1:0]  acc;

  for (genvar t = 0; t < NTAPS; t++) begin : g_mul
    logic signed [COEF_W-1:0] w;
    logic signed [AMP_W-1:0]  a;
    assign w = coef_i[t*COEF_W +: COEF_W];
    assign a = taps_i[t*AMP_W +: AMP_W];
    assign prod[t] = PROD_W'(w) * PROD_W'(a);
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < NTAPS; t++) acc = acc + ACC_W'(prod[t]);
  end

  always_comb begin
    if (acc > SAT_HI)      sat_o = SAT_HI[OUT_W-1:0];
    else if (acc < SAT_LO) sat_o = SAT_LO[OUT_W-1:0];
    else                   sat_o = acc[OUT_W-1:0];
  end
endmodule

// File: rtl/pam4_deemph_fir.sv
module pam4_deemph_fir
  import pam4_fir_pkg::*;
#(
  parameter int COEF_W     = 6,
  parameter int OUT_W      = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sym_i,
  input  logic              sym_vld_i,
  input  logic [COEF_W-1:0] coef_pre_i,
  input  logic [COEF_W-1:0] coef_main_i,
  input  logic [COEF_W-1:0] coef_post_i,
  input  logic              coef_load_i,
  output logic [OUT_W-1:0]  dac_o,
  output logic              dac_vld_o
);
  logic                    rst_sync_n;
  logic signed [AMP_W-1:0] amp_new;
  logic [NTAPS*COEF_W-1:0] coef_act;
  logic [NTAPS*AMP_W-1:0]  taps;
  logic [OUT_W-1:0]        sat_val;
  logic [OUT_W-1:0]        dac_q, dac_d;
  logic                    vld_q, vld_d;

  pam4_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pam4_sym_map u_map (.code_i(sym_i), .amp_o(amp_new));

  pam4_coef_bank #(.COEF_W(COEF_W), .NTAPS(NTAPS)) u_coef (
    .clk(clk), .rst_n(rst_sync_n), .load_i(coef_load_i),
    .coef_in_i({coef_post_i, coef_main_i, coef_pre_i}),
    .coef_o(coef_act)
  );

  pam4_tap_line #(.AMP_W(AMP_W), .NTAPS(NTAPS)) u_line (
    .clk(clk), .rst_n(rst_sync_n), .shift_i(sym_vld_i),
    .amp_i(amp_new), .taps_o(taps)
  );

  pam4_fir_core #(.COEF_W(COEF_W), .AMP_W(AMP_W), .OUT_W(OUT_W), .NTAPS(NTAPS)) u_core (
    .coef_i(coef_act), .taps_i(taps), .sat_o(sat_val)
  );

  always_comb begin
    dac_d = dac_q;
    vld_d = sym_vld_i;
    if (sym_vld_i) dac_d = sat_val;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dac_q <= '0;
      vld_q <= 1'b0;
    end else begin
      dac_q <= dac_d;
      vld_q <= vld_d;
    end
  end

  assign dac_o     = dac_q;
  assign dac_vld_o = vld_q;
endmodule

// File: rtl/pam4_fir_chk.sv
module pam4_fir_chk #(
  parameter int COEF_W = 6,
  parameter int OUT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_q_n,
  input logic [1:0]        sym_i,
  input logic              sym_vld_i,
  input logic [COEF_W-1:0] coef_pre_i,
  input logic [COEF_W-1:0] coef_main_i,
  input logic [COEF_W-1:0] coef_post_i,
  input logic              coef_load_i,
  input logic [OUT_W-1:0]  dac_o,
  input logic              dac_vld_o
);
  localparam int HI = (1 << (OUT_W-1)) - 1;
  localparam int LO = -HI - 1;

  function automatic int lvl(input logic [1:0] c);
    case (c)
      2'b00: lvl = -3;
      2'b01: lvl = -1;
      2'b11: lvl = 1;
      default: lvl = 3;
    endcase
  endfunction

  int m_p1, m_p2, m_wp, m_wm, m_wo, raw_q;
  int raw_now;

  always_comb raw_now = m_wp * lvl(sym_i) + m_wm * m_p1 + m_wo * m_p2;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      m_p1 <= 0; m_p2 <= 0; m_wp <= 0; m_wm <= 0; m_wo <= 0; raw_q <= 0;
    end else begin
      if (sym_vld_i) begin
        raw_q <= raw_now;
        m_p2  <= m_p1;
        m_p1  <= lvl(sym_i);
      end
      if (coef_load_i) begin
        m_wp <= int'($signed(coef_pre_i));
        m_wm <= int'($signed(coef_main_i));
        m_wo <= int'($signed(coef_post_i));
      end
    end
  end

  // R2: filter value matches independent model
  a_r2_fir_value: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dac_vld_o && raw_q <= HI && raw_q >= LO) |-> int'($signed(dac_o)) == raw_q);
  // R3: valid follows strobe by one clock
  a_r3_vld_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    sym_vld_i |=> dac_vld_o);
  a_r3_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_q_n)
    !sym_vld_i |=> !dac_vld_o);
  // R4: idle cycles freeze the output
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    !sym_vld_i |=> $stable(dac_o));
  // R5: clamping at both limits
  a_r5_clamp_hi: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dac_vld_o && raw_q > HI) |-> int'($signed(dac_o)) == HI);
  a_r5_clamp_lo: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dac_vld_o && raw_q < LO) |-> int'($signed(dac_o)) == LO);

  // R7: outputs cleared during reset
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r7_reset_clear: assert (dac_o == '0 && !dac_vld_o)
        else $error("R7 outputs not cleared in reset");
    end
  end
endmodule

bind pam4_deemph_fir pam4_fir_chk #(.COEF_W(COEF_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_q_n(rst_sync_n),
  .sym_i(sym_i), .sym_vld_i(sym_vld_i),
  .coef_pre_i(coef_pre_i), .coef_main_i(coef_main_i), .coef_post_i(coef_post_i),
  .coef_load_i(coef_load_i), .dac_o(dac_o), .dac_vld_o(dac_vld_o)
);

// File: tb/tb_pam4_deemph_fir.sv
module tb_pam4_deemph_fir;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sym_i;
  logic       sym_vld_i;
  logic [5:0] coef_pre_i, coef_main_i, coef_post_i;
  logic       coef_load_i;
  logic [7:0] dac_o;
  logic       dac_vld_o;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;
  int  hp1 = 0, hp2 = 0, kp = 0, km = 0, ko = 0;
  int  exp_out = 0;
  bit  exp_vld = 0;
  int  dp = 0, dm = 0, dpo = 0;

  always #2 clk = ~clk;

  pam4_deemph_fir dut (
    .clk(clk), .rst_n(rst_n), .sym_i(sym_i), .sym_vld_i(sym_vld_i),
    .coef_pre_i(coef_pre_i), .coef_main_i(coef_main_i), .coef_post_i(coef_post_i),
    .coef_load_i(coef_load_i), .dac_o(dac_o), .dac_vld_o(dac_vld_o)
  );

  function automatic int amp(input bit [1:0] c);
    case (c)
      2'b00: return -3;
      2'b01: return -1;
      2'b11: return 1;
      default: return 3;
    endcase
  endfunction

  function automatic int clamp(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // called at a falling edge; drives one cycle and checks the result
  task automatic step(input bit vld, input bit [1:0] s, input bit ld, input string req);
    string r;
    int raw;
    r = req;
    sym_i = s; sym_vld_i = vld; coef_load_i = ld;
    coef_pre_i = 6'(dp); coef_main_i = 6'(dm); coef_post_i = 6'(dpo);
    if (vld) begin
      raw = kp * amp(s) + km * hp1 + ko * hp2;
      if (raw != clamp(raw)) r = "R5";
      exp_out = clamp(raw);
      hp2 = hp1; hp1 = amp(s);
    end
    exp_vld = vld;
    if (ld) begin kp = dp; km = dm; ko = dpo; end
    @(negedge clk);
    coef_load_i = 1'b0;
    check(r, int'($signed(dac_o)), exp_out);
    check("R3", int'(dac_vld_o), int'(exp_vld));
  endtask

  task automatic load(input int p, input int m, input int o);
    dp = p; dm = m; dpo = o;
    step(1'b0, 2'b00, 1'b1, "R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int wp [8] = '{1, 0, 0, -5, 3, -32, 31, -32};
    int wm [8] = '{0, 0, 1, 20, -7, 31, 31, -32};
    int wo [8] = '{0, 1, 0, -3, 11, -32, 31, -32};
    int lit [4] = '{-3, -1, 3, 1};
    bit [15:0] lfsr;

    rst_n = 1'b0; sym_i = '0; sym_vld_i = 1'b0; coef_load_i = 1'b0;
    coef_pre_i = '0; coef_main_i = '0; coef_post_i = '0;
    repeat (3) @(negedge clk);
    check("R7", int'($signed(dac_o)), 0);
    check("R7", int'(dac_vld_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", int'($signed(dac_o)), 0);
    // weights reset to zero: first sample is zero
    step(1'b1, 2'b10, 1'b0, "R7");
    check("R7", int'($signed(dac_o)), 0);

    // R1: main tap only, literal level per code
    load(0, 1, 0);
    for (int b = 0; b < 4; b++) begin
      step(1'b1, 2'(b), 1'b0, "R1");
      step(1'b1, 2'b00, 1'b0, "R1");
      check("R1", int'($signed(dac_o)), lit[b]);
    end

    // R2/R5: all symbol triples over several weight sets
    for (int w = 0; w < 8; w++) begin
      load(wp[w], wm[w], wo[w]);
      for (int t = 0; t < 64; t++) begin
        step(1'b1, 2'(t >> 4), 1'b0, "R2");
        step(1'b1, 2'(t >> 2), 1'b0, "R2");
        step(1'b1, 2'(t), 1'b0, "R2");
      end
    end

    // R5: explicit limits
    load(31, 31, 31);
    step(1'b1, 2'b10, 1'b0, "R5"); step(1'b1, 2'b10, 1'b0, "R5");
    step(1'b1, 2'b10, 1'b0, "R5");
    check("R5", int'($signed(dac_o)), 127);
    load(31, 31, 31);
    step(1'b1, 2'b00, 1'b0, "R5"); step(1'b1, 2'b00, 1'b0, "R5");
    step(1'b1, 2'b00, 1'b0, "R5");
    check("R5", int'($signed(dac_o)), -128);

    // R4: idle cycles with changing symbols leave no trace
    load(7, -9, 5);
    step(1'b1, 2'b01, 1'b0, "R4");
    step(1'b1, 2'b10, 1'b0, "R4");
    for (int i = 0; i < 8; i++) step(1'b0, 2'(i), 1'b0, "R4");
    step(1'b1, 2'b11, 1'b0, "R4");
    check("R4", int'($signed(dac_o)), 7*1 + (-9)*3 + 5*(-1));

    // R6: weight inputs ignored without load
    dp = 31; dm = -32; dpo = 31;
    step(1'b1, 2'b00, 1'b0, "R6");
    step(1'b1, 2'b10, 1'b0, "R6");
    check("R6", int'($signed(dac_o)), 7*3 + (-9)*(-3) + 5*1);
    // R6: load coinciding with a symbol uses old weights for that sample
    dp = 1; dm = 2; dpo = 3;
    step(1'b1, 2'b01, 1'b1, "R6");
    check("R6", int'($signed(dac_o)), 7*(-1) + (-9)*3 + 5*(-3));
    step(1'b1, 2'b11, 1'b0, "R6");
    check("R6", int'($signed(dac_o)), 1*1 + 2*(-1) + 3*3);

    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[9:4] == 6'd0) begin
        dp = int'($signed(lfsr[15:10])); dm = int'($signed(lfsr[11:6]));
        dpo = int'($signed(lfsr[5:0]));
        step(lfsr[3], lfsr[1:0], 1'b1, "R6");
      end else begin
        step(lfsr[2] | lfsr[3], lfsr[1:0], 1'b0, "R2");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule